// File: doc/BRIEF.md
# Converter Output Demultiplexer with Double-Rate Data Clock

This block sits behind a sampling converter and turns its stream of samples into output buses for a downstream receiver. Each sample arrives with an out-of-range flag. In full-rate mode (1:1) every sample goes to one primary bus. In demultiplexed mode (1:2) the samples are grouped into pairs. The later sample of each pair goes to the primary bus and the earlier one to a delayed bus. Both buses update together at half the sample rate. A data clock is produced for the receiver to latch the data. It is a double-rate clock: each of its edges marks one output update. In 1:2 mode it can be placed in line with data changes or a quarter period later.

The block runs from an internal clock at twice the sample rate, so one sample slot covers two clock cycles. A two-bit phase counter sets the sample slots, the pairing and the data-clock edges. A synchronising pulse restarts that counter, so several such blocks can be aligned from a shared pulse.

Top module: `adc_out_demux`

## Requirements
- R1: While `rst_n` is low, every output is 0: both buses, both flags, `bus_d_oe` and `dclk_out`.
- R2: In 1:1 mode (`ndm_sel` = 1), the sample on `smp_in` is captured at the first clock edge of its two-cycle slot and appears on `bus_p` right after that edge. The slots are counted from the edge after a `dclk_sync` pulse. The primary bus then changes once per slot.
- R3: In 1:1 mode, `bus_d_oe` is 0 and `bus_d` and `bus_d_ovr` are held at 0.
- R4: In 1:2 mode (`ndm_sel` = 0), `bus_d_oe` is 1. Samples are paired as slot 2m and slot 2m+1. At the capture edge of slot 2m+1, `bus_p` takes sample 2m+1 and `bus_d` takes sample 2m, both in the same cycle.
- R5: Each `smp_ovr` value comes out on the flag of the bus that carries its sample, in the same cycle as that sample.
- R6: In 1:2 mode with `ddr_ph90` = 0, `dclk_out` toggles exactly at the edges where the pair is output, so it has a period of eight clocks (a quarter of the sample rate).
- R7: In 1:2 mode with `ddr_ph90` = 1, `dclk_out` toggles at the capture edge of the first sample of each pair. That places each data-clock edge two clocks after the bus update, in the middle of the four-cycle valid window.
- R8: In 1:1 mode, `dclk_out` toggles at every capture edge (half the sample rate), and `ddr_ph90` has no effect.
- R9: At an edge where `dclk_sync` is 1, the phase counter restarts, `dclk_out` goes to 0 and nothing is captured. The next slot is the first sample of a new pair, so the first pair after the pulse consists of the next two samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | SMP_W (12) | Converter sample, held for its two-cycle slot |
| smp_ovr | input | 1 | Out-of-range flag of `smp_in` |
| ndm_sel | input | 1 | 1 = 1:1 full-rate mode, 0 = 1:2 demultiplexed mode |
| ddr_ph90 | input | 1 | 1:2 mode only: 0 = clock edge in line with data, 1 = mid-window |
| dclk_sync | input | 1 | Synchronous restart of the data-clock divider |
| bus_p | output | SMP_W (12) | Primary bus (later sample of each pair in 1:2 mode) |
| bus_p_ovr | output | 1 | Flag travelling with `bus_p` |
| bus_d | output | SMP_W (12) | Delayed bus (earlier sample of each pair) |
| bus_d_ovr | output | 1 | Flag travelling with `bus_d` |
| bus_d_oe | output | 1 | Drive enable for the delayed bus |
| dclk_out | output | 1 | Double-rate output data clock |

## Verification
Edges are counted from the edge that sees `dclk_sync` high, which is edge 0. In 1:1 mode, sample k is due on `bus_p` after edge 2k+1. In 1:2 mode, pair m is due on both buses after edge 4m+3. The data clock's toggle count after edge n follows directly from which edges carry a toggle under the active mode and phase. The bench drives inputs at falling edges and reads outputs at the falling edge after each rising edge. Every result is therefore compared half a cycle after the single register stage that produces it, and data is compared only once the first result is due.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

   // two clocks per sample, two samples per pair
   localparam int unsigned PH_W = 2;
   typedef logic [PH_W-1:0] phase_t;

   localparam phase_t PH_PAIR_OPEN  = 2'd0;
   localparam phase_t PH_PAIR_CLOSE = 2'd2;

   function automatic logic is_slot_start(input phase_t ph);
      return ~ph[0];
   endfunction

endpackage

// File: rtl/demux_phase_ctr.sv
module demux_phase_ctr
   import adc_demux_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sync,
   output phase_t phase,
   output logic   cap_stb,
   output logic   pair_open,
   output logic   pair_close
);

   phase_t ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ph_q <= '0;
      else if (sync) ph_q <= '0;
      else           ph_q <= ph_q + 1'b1;
   end

   assign phase      = ph_q;
   assign cap_stb    = ~sync & is_slot_start(ph_q);
   assign pair_open  = ~sync & (ph_q == PH_PAIR_OPEN);
   assign pair_close = ~sync & (ph_q == PH_PAIR_CLOSE);

   // R9: a sync edge leaves the counter at its start phase
   a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (ph_q == PH_PAIR_OPEN));

endmodule

// File: rtl/demux_lane.sv
module demux_lane #(
   parameter int unsigned WORD_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ndm,
   input  logic              cap_stb,
   input  logic              pair_open,
   input  logic              pair_close,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] p_word,
   output logic [WORD_W-1:0] d_word,
   output logic              d_oe
);

   if (WORD_W < 2) begin : g_bad_width
      $error("demux_lane: WORD_W must hold a sample and its flag");
   end

   logic [WORD_W-1:0] early_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_word  <= '0;
         d_word  <= '0;
         early_q <= '0;
         d_oe    <= 1'b0;
      end else begin
         d_oe <= ~ndm;
         if (ndm) begin
            d_word <= '0;
            if (cap_stb) p_word <= din;
         end else begin
            if (pair_open) early_q <= din;
            if (pair_close) begin
               p_word <= din;
               d_word <= early_q;
            end
         end
      end
   end

   // R3: a disabled delayed bus carries nothing
   a_r3_idle_dly_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !d_oe |-> (d_word == '0));

   // R4: in 1:2 mode the delayed bus moves only where a pair closes
   a_r4_dly_at_close: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ndm) && (d_word != $past(d_word))) |-> $past(pair_close));

   // R2: in 1:1 mode the primary bus moves only at slot starts
   a_r2_prim_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ndm) && (p_word != $past(p_word))) |-> $past(cap_stb));

endmodule

// File: rtl/demux_dclk_gen.sv
module demux_dclk_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic sync,
   input  logic ndm,
   input  logic ph90,
   input  logic cap_stb,
   input  logic pair_open,
   input  logic pair_close,
   output logic dclk
);

   logic flip;

   always_comb begin
      if (ndm)       flip = cap_stb;
      else if (ph90) flip = pair_open;
      else           flip = pair_close;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dclk <= 1'b0;
      else if (sync) dclk <= 1'b0;
      else if (flip) dclk <= ~dclk;
   end

   // R6: in-line phase toggles only with a pair update
   a_r6_dclk_inline: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ndm) && !$past(ph90) && !$past(sync) && (dclk != $past(dclk)))
      |-> $past(pair_close));

   // R7: mid-window phase toggles only at pair open
   a_r7_dclk_mid: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ndm) && $past(ph90) && !$past(sync) && (dclk != $past(dclk)))
      |-> $past(pair_open));

   // R8: full-rate clock toggles at every slot start
   a_r8_dclk_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ndm && cap_stb) |=> (dclk != $past(dclk)));

   // R9: sync forces the clock low
   a_r9_dclk_low: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> !dclk);

endmodule

// File: rtl/adc_out_demux.sv
module adc_out_demux #(
   parameter int unsigned SMP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] smp_in,
   input  logic             smp_ovr,
   input  logic             ndm_sel,
   input  logic             ddr_ph90,
   input  logic             dclk_sync,
   output logic [SMP_W-1:0] bus_p,
   output logic             bus_p_ovr,
   output logic [SMP_W-1:0] bus_d,
   output logic             bus_d_ovr,
   output logic             bus_d_oe,
   output logic             dclk_out
);
   import adc_demux_pkg::*;

   localparam int unsigned WORD_W = SMP_W + 1;

   if (SMP_W < 1 || SMP_W > 32) begin : g_bad_smp_w
      $error("adc_out_demux: SMP_W out of range");
   end

   phase_t phase;
   logic   cap_stb, pair_open, pair_close;
   logic [WORD_W-1:0] in_word, p_word, d_word;

   assign in_word = {smp_ovr, smp_in};

   demux_phase_ctr u_ph (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync       (dclk_sync),
      .phase      (phase),
      .cap_stb    (cap_stb),
      .pair_open  (pair_open),
      .pair_close (pair_close)
   );

   demux_lane #(.WORD_W(WORD_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .ndm        (ndm_sel),
      .cap_stb    (cap_stb),
      .pair_open  (pair_open),
      .pair_close (pair_close),
      .din        (in_word),
      .p_word     (p_word),
      .d_word     (d_word),
      .d_oe       (bus_d_oe)
   );

   demux_dclk_gen u_dclk (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync       (dclk_sync),
      .ndm        (ndm_sel),
      .ph90       (ddr_ph90),
      .cap_stb    (cap_stb),
      .pair_open  (pair_open),
      .pair_close (pair_close),
      .dclk       (dclk_out)
   );

   assign bus_p     = p_word[SMP_W-1:0];
   assign bus_p_ovr = p_word[SMP_W];
   assign bus_d     = d_word[SMP_W-1:0];
   assign bus_d_ovr = d_word[SMP_W];

   // R4: in steady 1:2 mode both buses land in the same cycle
   a_r4_pair_together: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ndm_sel) && (bus_p != $past(bus_p)))
      |-> (phase == (PH_PAIR_CLOSE + 2'd1)));

   // R5: flag never outruns a disabled delayed bus
   a_r5_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_d_oe |-> !bus_d_ovr);

endmodule

// File: tb/adc_out_demux_test.sv
module adc_out_demux_test;
   localparam int  W   = 12;
   localparam time TCK = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] smp_in = '0;
   logic         smp_ovr = 1'b0;
   logic         ndm_sel = 1'b1;
   logic         ddr_ph90 = 1'b0;
   logic         dclk_sync = 1'b0;
   logic [W-1:0] bus_p, bus_d;
   logic         bus_p_ovr, bus_d_ovr, bus_d_oe, dclk_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(TCK/2) clk = ~clk;

   adc_out_demux #(.SMP_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_ovr(smp_ovr),
      .ndm_sel(ndm_sel), .ddr_ph90(ddr_ph90), .dclk_sync(dclk_sync),
      .bus_p(bus_p), .bus_p_ovr(bus_p_ovr), .bus_d(bus_d),
      .bus_d_ovr(bus_d_ovr), .bus_d_oe(bus_d_oe), .dclk_out(dclk_out)
   );

   function automatic logic [W-1:0] fs(int k, int seed);
      return W'((seed + k * 341) & 12'hFFF);
   endfunction

   function automatic logic fo(int k, int seed);
      return ((k + seed) % 3) == 0;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run(bit ndm, bit ph, int seed);
      @(negedge clk);
      ndm_sel   = ndm;
      ddr_ph90  = ph;
      dclk_sync = 1'b1;
      @(posedge clk);
      @(negedge clk);
      dclk_sync = 1'b0;
      chk("R9", "dclk after sync", int'(dclk_out), 0);
      for (int n = 1; n <= 42; n++) begin
         int k;
         k = (n - 1) / 2;
         smp_in  = fs(k, seed);
         smp_ovr = fo(k, seed);
         @(posedge clk);
         @(negedge clk);
         if (ndm) begin
            chk("R2", "bus_p 1:1", int'(bus_p), int'(fs(k, seed)));
            chk("R5", "bus_p_ovr 1:1", int'(bus_p_ovr), int'(fo(k, seed)));
            chk("R3", "oe 1:1", int'(bus_d_oe), 0);
            chk("R3", "bus_d 1:1", int'({bus_d_ovr, bus_d}), 0);
            chk(ph ? "R8" : "R8", ph ? "dclk 1:1 ph90 ignored" : "dclk 1:1",
                int'(dclk_out), (k + 1) & 1);
         end else begin
            chk("R4", "oe 1:2", int'(bus_d_oe), 1);
            if (n >= 3) begin
               int m;
               m = (n - 3) / 4;
               chk("R4", "bus_p later", int'(bus_p), int'(fs(2*m+1, seed)));
               chk("R4", "bus_d earlier", int'(bus_d), int'(fs(2*m, seed)));
               chk("R5", "bus_p_ovr", int'(bus_p_ovr), int'(fo(2*m+1, seed)));
               chk("R5", "bus_d_ovr", int'(bus_d_ovr), int'(fo(2*m, seed)));
               if (m == 0) chk("R9", "first pair after sync", int'(bus_d), int'(fs(0, seed)));
            end
            if (ph)
               chk("R7", "dclk mid", int'(dclk_out), ((n - 1) / 4 + 1) & 1);
            else
               chk("R6", "dclk inline", int'(dclk_out), (n >= 3) ? (((n - 3) / 4 + 1) & 1) : 0);
         end
      end
   endtask

   initial begin
      #(TCK * 3);
      @(negedge clk);
      chk("R1", "bus_p reset", int'({bus_p_ovr, bus_p}), 0);
      chk("R1", "bus_d reset", int'({bus_d_ovr, bus_d}), 0);
      chk("R1", "oe reset", int'(bus_d_oe), 0);
      chk("R1", "dclk reset", int'(dclk_out), 0);
      rst_n = 1'b1;
      run(1'b1, 1'b0, 12'h000);
      run(1'b1, 1'b1, 12'hF3C);
      run(1'b0, 1'b0, 12'h5A5);
      run(1'b0, 1'b1, 12'hFFF);
      run(1'b1, 1'b1, 12'h801);
      run(1'b0, 1'b0, 12'h07E);
      run(1'b0, 1'b1, 12'h3C3);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule